// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This block performs hardware handshaking for one channel of a 16550-style UART. On the receive side it watches the receive FIFO occupancy, character-arrival events and CPU reads of the receive buffer. It pulls the RTS output inactive when the FIFO fills to its trigger threshold, or when the last free slot starts to fill. It lets RTS go active again once the CPU reads the final byte. On the transmit side it synchronizes the incoming CTS line. It produces a start permission, `tx_go`, for the serializer. CTS is judged at the midpoint of each stop bit. If CTS is inactive there, the next character is held back. A character that has already been granted or started is never cut short.

A single enable bit switches automatic control on. When it is clear, RTS and DTR are registered copies of the modem control bits and the transmitter is never held. All outputs are registered. All reactions take one to three system clocks. The system clock is at least as fast as the baud clock, so every limit of two baud cycles (RTS) and twenty-four baud cycles (CTS to start) is met.

Top module: `uart_autoflow`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rts_out`, `dtr_out` and `tx_go` are 0.
- R2: With `afc_en` = 0, `rts_out` and `dtr_out` equal the values `mcr_rts` and `mcr_dtr` had one clock earlier, and `tx_go` is 1 one clock after any cycle with `afc_en` = 0, whatever `cts_in` is.
- R3: With `afc_en` = 1, an `rx_char_done` pulse is seen while `rx_level` + 1 >= `trig_level`. `rx_level` is the count before that character is stored. `rts_out` is then 0 one clock later.
- R4: With `afc_en` = 1 and `mcr_rts` = 1, an `rbr_read` pulse is seen while `rx_level` = 1 and no drop event is present. `rts_out` is then 1 one clock later.
- R5: With `afc_en` = 1, an `rx_first_data` pulse is seen while `rx_level` >= DEPTH-1, which is the first data bit of the character that would fill the last slot. `rts_out` is then 0 one clock later.
- R6: A read with `rx_level` other than 1 does not restore RTS. An arrival with `rx_level` + 1 below `trig_level` does not drop RTS. A first-data pulse with `rx_level` below DEPTH-1 does not drop RTS. Once dropped, RTS stays 0 until a restore.
- R7: When a drop event (R3 or R5) and a restore event (R4) occur in the same cycle, the drop wins and `rts_out` is 0.
- R8: With `afc_en` = 1 and no granted character, `tx_go` follows `cts_in` (1 = clear to send) with exactly three clocks of latency: two synchronizer stages and one output register.
- R9: At a `tx_stop_mid` pulse with `tx_req` = 1, a synchronized CTS of 1 grants the next character. `tx_go` then stays 1 even if CTS drops, until `tx_start`. A synchronized CTS of 0 at that pulse keeps `tx_go` at 0.
- R10: A grant is withdrawn by `tx_start` or by `tx_req` = 0. `tx_go` then follows synchronized CTS again one clock later.
- R11: `rts_out` is 0 one clock after any cycle with `mcr_rts` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| afc_en | input | 1 | Automatic flow control enable |
| mcr_rts | input | 1 | Modem control RTS bit |
| mcr_dtr | input | 1 | Modem control DTR bit |
| trig_level | input | $clog2(DEPTH+1) | Receive threshold in characters |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy before the current event |
| rx_char_done | input | 1 | Pulse: a received character is being stored |
| rx_first_data | input | 1 | Pulse: first data bit of an incoming character |
| rbr_read | input | 1 | Pulse: CPU read of the receive buffer begins |
| cts_in | input | 1 | Asynchronous clear-to-send, 1 = active |
| tx_req | input | 1 | Transmitter has a character waiting |
| tx_start | input | 1 | Pulse: transmitter begins a start bit |
| tx_stop_mid | input | 1 | Pulse: midpoint of the current stop bit |
| rts_out | output | 1 | Request-to-send, 1 = active |
| dtr_out | output | 1 | Data-terminal-ready, 1 = active |
| tx_go | output | 1 | Permission for the next start bit |

## Verification
On the receive side, a threshold arrival and a read of the last byte can land in the same clock. This happens with `trig_level` = 1 and `rx_level` = 1. The bench drives both pulses together in a directed case and expects RTS to drop (R7). The random phase mixes arrival, first-data and read pulses with random levels and enables. There, a bench model that applies drop-before-restore judges every cycle. On the transmit side, a CTS drop in flight at a stop-bit grant is provoked directly. The bench checks that permission holds until the start pulse.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;

  // Receive-side events seen in one clock
  typedef struct packed {
    logic done;   // character being stored
    logic first;  // first data bit of an incoming character
    logic rd;     // CPU read of the receive buffer
  } rx_evt_t;

endpackage

// File: rtl/afc_cts_sync.sv
module afc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // Synchronizer flops carry no reset so that they never mask a CTS edge
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

  // R8: two-stage latency of the synchronized CTS
  a_r8_sync_latency: assert property (@(posedge clk) disable iff (rst)
    (STAGES == 2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
  import uart_afc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          afc_en,
  input  logic          mcr_rts,
  input  logic [CW-1:0] trig_level,
  input  logic [CW-1:0] rx_level,
  input  rx_evt_t       ev,
  output logic          rts_out
);

  localparam logic [CW-1:0] LAST_SLOT = CW'(DEPTH - 1);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW:0] level_after;
  logic        drop_c, restore_c;
  logic        hold_q, hold_d;

  assign level_after = {1'b0, rx_level} + {{CW{1'b0}}, 1'b1};
  assign drop_c      = (ev.done  && (level_after >= {1'b0, trig_level}))
                    || (ev.first && (rx_level >= LAST_SLOT));
  assign restore_c   = ev.rd && (rx_level == ONE);

  // Drop takes priority over restore (R7)
  always_comb begin
    hold_d = hold_q;
    if (!afc_en)        hold_d = 1'b0;
    else if (drop_c)    hold_d = 1'b1;
    else if (restore_c) hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      rts_out <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      rts_out <= mcr_rts && !hold_d;
    end
  end

  a_r3_threshold_drop: assert property (@(posedge clk) disable iff (rst)
    (afc_en && ev.done && ({1'b0, rx_level} + 1'b1 >= {1'b0, trig_level}))
      |=> !rts_out);

  a_r5_last_slot_drop: assert property (@(posedge clk) disable iff (rst)
    (afc_en && ev.first && (rx_level >= LAST_SLOT)) |=> !rts_out);

  a_r4_drain_restore: assert property (@(posedge clk) disable iff (rst)
    (afc_en && mcr_rts && ev.rd && (rx_level == ONE) && !ev.done && !ev.first)
      |=> rts_out);

  a_r11_mcr_gate: assert property (@(posedge clk) disable iff (rst)
    !mcr_rts |=> !rts_out);

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic afc_en,
  input  logic cts_s,
  input  logic tx_req,
  input  logic tx_start,
  input  logic tx_stop_mid,
  output logic tx_go
);

  logic grant_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      tx_go   <= 1'b0;
    end else begin
      if (tx_start || !tx_req || !afc_en) grant_q <= 1'b0;
      else if (tx_stop_mid && cts_s)      grant_q <= 1'b1;
      tx_go <= !afc_en || cts_s || grant_q;
    end
  end

  a_r2_no_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !afc_en |=> tx_go);

  // R9: a granted character is not held back by a late CTS drop
  a_r9_grant_kept: assert property (@(posedge clk) disable iff (rst)
    (afc_en && grant_q && tx_req && !tx_start) |=> tx_go);

  // R10: the grant never survives a start bit
  a_r10_grant_cleared: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !grant_q);

endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_afc_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          afc_en,
  input  logic          mcr_rts,
  input  logic          mcr_dtr,
  input  logic [CW-1:0] trig_level,
  input  logic [CW-1:0] rx_level,
  input  logic          rx_char_done,
  input  logic          rx_first_data,
  input  logic          rbr_read,
  input  logic          cts_in,
  input  logic          tx_req,
  input  logic          tx_start,
  input  logic          tx_stop_mid,
  output logic          rts_out,
  output logic          dtr_out,
  output logic          tx_go
);

  rx_evt_t ev;
  logic    cts_s;

  assign ev = '{done: rx_char_done, first: rx_first_data, rd: rbr_read};

  afc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cts_in),
    .dout (cts_s)
  );

  afc_rts_ctrl #(.DEPTH(DEPTH)) u_rts (
    .clk        (clk),
    .rst        (rst),
    .afc_en     (afc_en),
    .mcr_rts    (mcr_rts),
    .trig_level (trig_level),
    .rx_level   (rx_level),
    .ev         (ev),
    .rts_out    (rts_out)
  );

  afc_tx_gate u_tx (
    .clk         (clk),
    .rst         (rst),
    .afc_en      (afc_en),
    .cts_s       (cts_s),
    .tx_req      (tx_req),
    .tx_start    (tx_start),
    .tx_stop_mid (tx_stop_mid),
    .tx_go       (tx_go)
  );

  always_ff @(posedge clk) begin
    if (rst) dtr_out <= 1'b0;
    else     dtr_out <= mcr_dtr;
  end

  a_r2_dtr_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dtr_out == $past(mcr_dtr)));

endmodule

// File: tb/uart_autoflow_bench.sv
module uart_autoflow_bench;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic afc_en = 1'b0, mcr_rts = 1'b0, mcr_dtr = 1'b0;
  logic [CW-1:0] trig_level = '0, rx_level = '0;
  logic rx_char_done = 1'b0, rx_first_data = 1'b0, rbr_read = 1'b0;
  logic cts_in = 1'b0, tx_req = 1'b0, tx_start = 1'b0, tx_stop_mid = 1'b0;
  logic rts_out, dtr_out, tx_go;

  int checks = 0;
  int failures = 0;
  bit model_hold = 1'b0;

  always #4 clk = ~clk;

  uart_autoflow #(.DEPTH(DEPTH)) u_uart_autoflow (
    .clk(clk), .rst(rst), .afc_en(afc_en), .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr),
    .trig_level(trig_level), .rx_level(rx_level), .rx_char_done(rx_char_done),
    .rx_first_data(rx_first_data), .rbr_read(rbr_read), .cts_in(cts_in),
    .tx_req(tx_req), .tx_start(tx_start), .tx_stop_mid(tx_stop_mid),
    .rts_out(rts_out), .dtr_out(dtr_out), .tx_go(tx_go)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of the receive hold state
  function automatic bit next_hold(bit h, bit en, bit done, bit first, bit rd,
                                   int lvl, int trig);
    if (!en) return 1'b0;
    if ((done && (lvl + 1 >= trig)) || (first && (lvl >= DEPTH - 1))) return 1'b1;
    if (rd && (lvl == 1)) return 1'b0;
    return h;
  endfunction

  task automatic clear_pulses();
    rx_char_done = 0; rx_first_data = 0; rbr_read = 0;
    tx_start = 0; tx_stop_mid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mcr_rts = 1; mcr_dtr = 1; cts_in = 1;
    repeat (3) tick();
    check("R1 rts in reset", rts_out, 1'b0);
    check("R1 dtr in reset", dtr_out, 1'b0);
    check("R1 tx_go in reset", tx_go, 1'b0);
    rst = 0;
    tick();
    check("R1 rts after release", rts_out, 1'b1);

    // R2: automatic control off
    afc_en = 0; mcr_rts = 0; mcr_dtr = 1; cts_in = 0;
    tick();
    check("R2 rts follows mcr", rts_out, 1'b0);
    check("R2 dtr follows mcr", dtr_out, 1'b1);
    mcr_rts = 1; mcr_dtr = 0;
    trig_level = CW'(1); rx_level = CW'(5); rx_char_done = 1;
    tick(); clear_pulses();
    check("R2 rts ignores threshold when off", rts_out, 1'b1);
    check("R2 dtr follows mcr low", dtr_out, 1'b0);
    repeat (3) tick();
    check("R2 tx_go with CTS inactive", tx_go, 1'b1);

    // R3: threshold drop
    afc_en = 1; cts_in = 1; mcr_dtr = 1;
    trig_level = CW'(8); rx_level = CW'(6); rx_char_done = 1;
    tick(); clear_pulses();
    check("R6 below-threshold arrival keeps rts", rts_out, 1'b1);
    rx_level = CW'(7); rx_char_done = 1;
    tick(); clear_pulses();
    check("R3 threshold arrival drops rts", rts_out, 1'b0);
    // R6: non-last reads do not restore
    rx_level = CW'(3); rbr_read = 1;
    tick(); clear_pulses();
    check("R6 read of non-last byte keeps rts low", rts_out, 1'b0);
    tick();
    check("R6 drop persists", rts_out, 1'b0);
    // R4: read of the last byte restores
    rx_level = CW'(1); rbr_read = 1;
    tick(); clear_pulses();
    check("R4 last-byte read restores rts", rts_out, 1'b1);

    // R5: first data bit of the character filling the last slot
    trig_level = CW'(16);
    rx_level = CW'(14); rx_first_data = 1;
    tick(); clear_pulses();
    check("R6 first data with free room keeps rts", rts_out, 1'b1);
    rx_level = CW'(15); rx_first_data = 1;
    tick(); clear_pulses();
    check("R5 last-slot first data drops rts", rts_out, 1'b0);
    rx_level = CW'(1); rbr_read = 1;
    tick(); clear_pulses();
    check("R4 restore after last-slot drop", rts_out, 1'b1);

    // R7: drop and restore in the same cycle
    trig_level = CW'(1); rx_level = CW'(1); rx_char_done = 1; rbr_read = 1;
    tick(); clear_pulses();
    check("R7 drop wins over restore", rts_out, 1'b0);
    rbr_read = 1;
    tick(); clear_pulses();
    check("R4 restore after tie", rts_out, 1'b1);

    // R11: mcr gate while auto control is on
    mcr_rts = 0;
    tick();
    check("R11 rts low with mcr low", rts_out, 1'b0);
    mcr_rts = 1;
    tick();
    check("R11 rts back with mcr high", rts_out, 1'b1);

    // R8: CTS latency (no grant: tx_req low)
    tx_req = 0; cts_in = 0;
    tick(); tick();
    check("R8 tx_go unchanged after two clocks", tx_go, 1'b1);
    tick();
    check("R8 tx_go low after three clocks", tx_go, 1'b0);
    cts_in = 1;
    tick(); tick();
    check("R8 tx_go still low after two clocks", tx_go, 1'b0);
    tick();
    check("R8 tx_go high after three clocks", tx_go, 1'b1);

    // R9: grant at stop midpoint survives a later CTS drop
    tx_req = 1; tx_stop_mid = 1;
    tick(); clear_pulses();
    cts_in = 0;
    repeat (5) tick();
    check("R9 granted character not held", tx_go, 1'b1);
    // R10: start bit consumes the grant
    tx_start = 1;
    tick(); clear_pulses();
    tick();
    check("R10 tx_go drops after start with CTS low", tx_go, 1'b0);
    // R9: CTS inactive at stop midpoint holds the next character
    tx_stop_mid = 1;
    tick(); clear_pulses();
    repeat (3) tick();
    check("R9 CTS low at stop midpoint holds", tx_go, 1'b0);
    // R10: grant withdrawn when no character waits
    cts_in = 1;
    repeat (3) tick();
    tx_stop_mid = 1;
    tick(); clear_pulses();
    cts_in = 0; tx_req = 0;
    tick();
    repeat (3) tick();
    check("R10 grant withdrawn by tx_req low", tx_go, 1'b0);

    // Random phase for the receive side (R3/R4/R5/R6/R7/R11/R2)
    afc_en = 1; mcr_rts = 1;
    rx_level = CW'(1); rbr_read = 1;
    tick(); clear_pulses();
    model_hold = 1'b0;
    for (int n = 0; n < 600; n++) begin
      int lvl, trig;
      bit exp_rts;
      lvl  = $urandom % (DEPTH + 1);
      trig = (($urandom % 4) == 0) ? 1 : (4 + 4 * ($urandom % 3));
      afc_en  = (($urandom % 10) != 0);
      mcr_rts = (($urandom % 8) != 0);
      mcr_dtr = $urandom % 2;
      rx_level = CW'(lvl); trig_level = CW'(trig);
      rx_char_done  = (($urandom % 3) == 0);
      rx_first_data = (($urandom % 4) == 0);
      rbr_read      = (($urandom % 3) == 0);
      if (($urandom % 4) == 0) rx_level = CW'(1);
      lvl = int'(rx_level);
      model_hold = next_hold(model_hold, afc_en, rx_char_done, rx_first_data,
                             rbr_read, lvl, trig);
      exp_rts = mcr_rts && !model_hold;
      tick();
      check("R3/R4/R5/R6/R7 random rts", rts_out, exp_rts);
      check("R2 random dtr", dtr_out, mcr_dtr);
      clear_pulses();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule